// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz timebase tick into two related outputs for a real-time clock: a one-cycle periodic event, which feeds the interrupt flag logic, and a square wave. A 4-bit rate-select input chooses the rate for both outputs. The slowest setting gives a 500 ms interval and the fastest gives about 122 µs. The block works apart from any alarm logic. It has no register interface of its own. The surrounding logic drives the select field and the square-wave enable directly.

The timebase arrives as a one-clock-wide enable, `tickIn`, on the system clock. A single counter counts these ticks. The select value sets the counter's terminal count, and it also sets the counter bit that forms the square wave. Because of this, the event and the square wave always share one period. Any change of the select value restarts the count.

Top module: `rtc_periodic_gen`

## Requirements
- R1: After reset, `periodicEvt` and `sqwOut` are both low.
- R2: While `rateSel` is 0, no event is produced, `sqwOut` stays low and the count is held at zero.
- R3: For `rateSel` from 3 to 15, an event occurs once every 2^(rateSel-1) ticks. This gives 4 ticks (8192 Hz) at 3 and 16384 ticks (2 Hz) at 15.
- R4: `rateSel` 1 gives one event every 128 ticks (256 Hz). `rateSel` 2 gives one event every 256 ticks (128 Hz).
- R5: `periodicEvt` is high for exactly one clock cycle. That cycle follows the clock edge at which the tick that completes a period was sampled.
- R6: `sqwOut` has the same period as the event. It is low for the first half of each period and high for the second half. It rises after half the ticks of the period and falls in the same cycle that `periodicEvt` is raised.
- R7: When `sqwEn` is 0, `sqwOut` is low. `sqwEn` has no effect on `periodicEvt`.
- R8: A clock edge at which `rateSel` differs from its value at the previous edge restarts the count at zero and produces no event, even if a completing tick is present. The tick at that edge is not counted. The first event comes after one full new period of ticks.
- R9: Clock cycles with `tickIn` low do not advance the count. Every event follows an edge at which `tickIn` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-cycle enable at the 32.768 kHz timebase rate |
| rateSel | input | 4 | Rate select; 0 turns both outputs off |
| sqwEn | input | 1 | Square-wave output enable |
| periodicEvt | output | 1 | One-cycle periodic event pulse |
| sqwOut | output | 1 | Square wave at the selected rate |

## Verification
The two functions that can coincide are the restart on a change of `rateSel` and the tick that would finish the current period. The bench provokes this by watching its own model. When the count stands one tick short of the terminal value and a tick is being presented, the bench changes `rateSel` in that same cycle. The result is judged by requiring that no event appears in the following cycle. The next event must then come exactly one new period later, which is the restart-wins rule of R8. The same cycle-by-cycle comparison also covers a square-wave enable change that lands on an event cycle: the event must still appear while `sqwOut` drops.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RS_W  = 4;
  localparam int EXP_W = 4;
  localparam int CNT_W = 14;

  typedef struct packed {
    logic restart;
    logic advance;
    logic active;
  } ctlStrb_t;

  // log2 of the period in ticks for a given select value
  function automatic logic [EXP_W-1:0] rateExp(input logic [RS_W-1:0] rs);
    logic [EXP_W-1:0] e;
    case (rs)
      RS_W'(0): e = EXP_W'(1);
      RS_W'(1): e = EXP_W'(7);
      RS_W'(2): e = EXP_W'(8);
      default:  e = EXP_W'(rs - RS_W'(1));
    endcase
    return e;
  endfunction
endpackage

// File: rtl/rtc_rate_ctrl.sv
module rtc_rate_ctrl
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tickIn,
  input  logic [RS_W-1:0] rateSel,
  output ctlStrb_t        strb,
  output logic [EXP_W-1:0] perExp
);
  logic [RS_W-1:0] prevSel;
  logic            selChanged;
  logic            isActive;

  always_ff @(posedge clk) begin
    if (!rst_n) prevSel <= '0;
    else        prevSel <= rateSel;
  end

  assign selChanged   = (rateSel != prevSel);
  assign isActive     = (rateSel != '0);
  assign strb.active  = isActive;
  assign strb.restart = selChanged || !isActive;
  assign strb.advance = tickIn && isActive && !selChanged;
  assign perExp       = rateExp(rateSel);
endmodule

// File: rtl/rtc_rate_dp.sv
module rtc_rate_dp
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrb_t         strb,
  input  logic [EXP_W-1:0] perExp,
  input  logic             sqwEn,
  output logic             periodicEvt,
  output logic             sqwOut
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   periodLen;
  logic             lastTick;
  logic             evtReg;

  assign periodLen = (CNT_W+1)'(1) << perExp;
  assign lastTick  = ({1'b0, cnt} == (periodLen - (CNT_W+1)'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      evtReg <= 1'b0;
    end else if (strb.restart) begin
      cnt    <= '0;
      evtReg <= 1'b0;
    end else if (strb.advance) begin
      if (lastTick) begin
        cnt    <= '0;
        evtReg <= 1'b1;
      end else begin
        cnt    <= cnt + CNT_W'(1);
        evtReg <= 1'b0;
      end
    end else begin
      evtReg <= 1'b0;
    end
  end

  assign periodicEvt = evtReg;
  // upper half of the count forms the high phase
  assign sqwOut = sqwEn && strb.active && cnt[perExp - EXP_W'(1)];
endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tickIn,
  input  logic [RS_W-1:0] rateSel,
  input  logic            sqwEn,
  output logic            periodicEvt,
  output logic            sqwOut
);
  ctlStrb_t         strb;
  logic [EXP_W-1:0] perExp;

  rtc_rate_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .tickIn (tickIn),
    .rateSel(rateSel),
    .strb   (strb),
    .perExp (perExp)
  );

  rtc_rate_dp u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .perExp     (perExp),
    .sqwEn      (sqwEn),
    .periodicEvt(periodicEvt),
    .sqwOut     (sqwOut)
  );
endmodule

// File: rtl/rtc_periodic_chk.sv
module rtc_periodic_chk
  import rtc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            tickIn,
  input logic [RS_W-1:0] rateSel,
  input logic            sqwEn,
  input logic            periodicEvt,
  input logic            sqwOut
);
  // R5: pulse never lasts two cycles
  p_evt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    periodicEvt |=> !periodicEvt);

  // R7: disabled square wave stays low
  p_sqw_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sqwEn |-> !sqwOut);

  // R2: idle select gives no square wave and no following event
  p_idle_sqw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rateSel == '0) |-> !sqwOut);
  p_idle_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rateSel == '0) |=> !periodicEvt);

  // R8: an edge with a changed select yields no event
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rateSel != $past(rateSel)) |=> !periodicEvt);

  // R9: every event follows a sampled tick
  p_tick_needed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    periodicEvt |-> $past(tickIn));
endmodule

bind rtc_periodic_gen rtc_periodic_chk u_chk (.*);

// File: tb/sim_rtc_periodic_gen.sv
module sim_rtc_periodic_gen;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickIn = 1'b0;
  logic [3:0] rateSel = 4'd0;
  logic       sqwEn = 1'b0;
  logic       periodicEvt, sqwOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int  mCnt = 0;
  int  mPrev = 0;
  bit  mEvt = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_periodic_gen u0 (
    .clk(clk), .rst_n(rst_n), .tickIn(tickIn), .rateSel(rateSel),
    .sqwEn(sqwEn), .periodicEvt(periodicEvt), .sqwOut(sqwOut)
  );

  function automatic int periodOf(input int rs);
    if (rs == 1) return 128;
    if (rs == 2) return 256;
    return 1 << (rs - 1);
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkInt(input string req, input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model update
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mCnt = 0; mEvt = 0; mPrev = 0;
    end else begin
      if (int'(rateSel) != mPrev || rateSel == 0) begin
        mCnt = 0; mEvt = 0;
      end else if (tickIn) begin
        if (mCnt == periodOf(rateSel) - 1) begin mCnt = 0; mEvt = 1; end
        else begin mCnt++; mEvt = 0; end
      end else mEvt = 0;
      mPrev = rateSel;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R5", periodicEvt, mEvt, "periodicEvt");
      check("R6", sqwOut,
            sqwEn && rateSel != 0 && (mCnt >= periodOf(rateSel) / 2), "sqwOut");
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > MAX_CYC && !finished) begin
      finished = 1'b1;
      nFails++; nChecks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, MAX_CYC);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // set select and count cycles (tick every cycle) to first and second event
  task automatic measure(input string req, input int rs);
    int c;
    @(negedge clk);
    rateSel = 4'(rs); tickIn = 1'b1;
    c = 0;
    do begin @(negedge clk); c++; end while (!periodicEvt && c < 40000);
    checkInt(req, c, periodOf(rs) + 1, "cycles from write to first event (R8)");
    c = 0;
    do begin @(negedge clk); c++; end while (!periodicEvt && c < 40000);
    checkInt(req, c, periodOf(rs), "cycles between events");
  endtask

  initial begin
    cyc(3);
    check("R1", periodicEvt, 1'b0, "reset periodicEvt");
    check("R1", sqwOut, 1'b0, "reset sqwOut");
    @(negedge clk); rst_n = 1'b1; sqwEn = 1'b1;

    // R2: idle select with ticks running
    tickIn = 1'b1;
    cyc(50);
    check("R2", sqwOut, 1'b0, "idle sqwOut");

    measure("R3", 3);
    measure("R3", 7);
    measure("R3", 15);
    measure("R4", 1);
    measure("R4", 2);

    // R7: enable off, events keep flowing
    begin
      int evts = 0;
      @(negedge clk); rateSel = 4'd4; sqwEn = 1'b0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (periodicEvt) evts++;
        check("R7", sqwOut, 1'b0, "sqwOut while disabled");
      end
      checkInt("R7", evts, 12, "events with sqwEn low");
      sqwEn = 1'b1;
    end

    // R9: sparse ticks, one every third cycle
    @(negedge clk); rateSel = 4'd5;
    for (int i = 0; i < 600; i++) begin
      tickIn = (i % 3 == 0);
      @(negedge clk);
    end
    tickIn = 1'b1;

    // R8: select change in the very cycle a completing tick is presented
    rateSel = 4'd3;
    cyc(10);
    while (mCnt != periodOf(3) - 1) @(negedge clk);
    rateSel = 4'd4;
    @(negedge clk);
    check("R8", periodicEvt, 1'b0, "event suppressed by restart");
    begin
      int c = 1;
      while (!periodicEvt && c < 100) begin @(negedge clk); c++; end
      checkInt("R8", c, periodOf(4) + 1, "first event after colliding write");
    end

    // R7: enable dropped on an event cycle
    while (mCnt != periodOf(4) - 1) @(negedge clk);
    @(negedge clk);
    sqwEn = 1'b0;
    check("R7", periodicEvt, 1'b1, "event present with sqwEn dropped");
    cyc(20);
    sqwEn = 1'b1;

    // R2: back to idle
    rateSel = 4'd0;
    cyc(100);
    check("R2", periodicEvt, 1'b0, "idle event");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule